// File: doc/BRIEF.md
# Tag Check Fault Mode Dispatcher

This block decides what happens once a memory tag comparison has failed. For each failure event it takes the faulting address, whether the access was a store, which translation regime issued it and the relevant control register mode bits. From these it selects one of four reporting policies. The failure can be dropped. It can become a synchronous data abort request that carries the faulting address and the access direction. It can set a sticky bit in an asynchronous fault status register kept for the current exception level. In the mixed policy, stores are reported asynchronously and loads raise the synchronous abort.

Four status registers are held inside the block, one for each exception level. A register port reads and writes them. A write replaces the stored value and is the only way to clear a bit. A failure that arrives in the same cycle as a write is merged on top of the written value. The block does not vector exceptions. It only presents the abort request for a downstream exception unit.

Top module: `tcf_dispatch`

## Requirements
- R1: After reset, `abort_vld` is 0 and all four status registers read 0.
- R2: The mode comes from `ctrl_tcf[1:0]` when `regime_user` is 1 and from `ctrl_tcf[3:2]` otherwise. These correspond to control bits [39:38] and [41:40]. The other pair has no effect.
- R3: Mode 0 (ignore): a failure produces no abort and changes no status bit.
- R4: Mode 1 (synchronous): one cycle after the failure, `abort_vld` is 1, `abort_addr` equals the failing address and `abort_wr` equals the failing access's write flag. No status bit changes.
- R5: Mode 2 (asynchronous): a failure sets one bit of the status register selected by `fault_lvl` and produces no abort.
- R6: Mode 3 (asymmetric): a failing store behaves as mode 2 and a failing load behaves as mode 1.
- R7: The status bit index is `fail_addr[55]` when `regime_two_ranges` is 1 and 0 otherwise. Bit 0 is `reg_rdata[0]` and bit 1 is `reg_rdata[1]`.
- R8: Status bits stay set until a register write (`reg_wr_en`) to that level replaces them with `reg_wdata`. A failure in the same cycle as a write to the same level is ORed into the written value.
- R9: `abort_vld` is a one-cycle pulse for each failure that calls for a synchronous abort, and it never rises without a failure.
- R10: The status registers of different levels are independent. `reg_rdata` shows the register of `reg_lvl` one cycle after `reg_lvl` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fail_vld | input | 1 | Tag check failure event this cycle |
| fail_addr | input | 64 | Virtual address of the failing granule |
| fail_wr | input | 1 | 1 = failing access was a store |
| regime_user | input | 1 | 1 = user-level translation regime |
| regime_two_ranges | input | 1 | 1 = regime has two address ranges |
| ctrl_tcf | input | 4 | Control mode bits: [1:0] user regime, [3:2] other regimes |
| fault_lvl | input | 2 | Exception level whose status register a failure sets |
| reg_wr_en | input | 1 | Register write strobe |
| reg_lvl | input | 2 | Status register selected for read and write |
| reg_wdata | input | 2 | Value written to the selected status register |
| reg_rdata | output | 2 | Registered read of the selected status register |
| abort_vld | output | 1 | Synchronous data abort request pulse |
| abort_addr | output | 64 | Fault virtual address for the abort |
| abort_wr | output | 1 | Write flag for the abort syndrome |

## Verification
A wrong mode decode or a wrong routing decision shows on the abort outputs in the cycle right after the failure: a missing or extra `abort_vld` pulse, or a wrong address or direction. A wrong status bit does not show until the affected level is read back. The read lags by one register, so each asynchronous case reads its level directly after the failure, and it also reads untouched levels to catch writes that land on the wrong register. The clear-and-merge case drives a write and a failure in the same cycle, so a wrong priority appears in the very next read.

// File: rtl/tcf_pkg.sv
package tcf_pkg;
  typedef enum logic [1:0] {
    TCF_IGNORE = 2'd0,
    TCF_SYNC   = 2'd1,
    TCF_ASYNC  = 2'd2,
    TCF_ASYM   = 2'd3
  } tcf_mode_e;
endpackage

// File: rtl/tcf_mode_sel.sv
module tcf_mode_sel
  import tcf_pkg::*;
#(
  parameter int MODE_W = 2
) (
  input  logic [2*MODE_W-1:0] ctrl_tcf,
  input  logic                regime_user,
  output tcf_mode_e           mode
);
  // low pair serves the user regime, high pair every other regime
  always_comb begin
    if (regime_user) mode = tcf_mode_e'(ctrl_tcf[MODE_W-1:0]);
    else             mode = tcf_mode_e'(ctrl_tcf[2*MODE_W-1:MODE_W]);
  end
endmodule

// File: rtl/tcf_route.sv
module tcf_route
  import tcf_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int SEL_BIT  = 55,
  parameter int STATUS_W = 2,
  localparam int IDX_W   = (STATUS_W > 1) ? $clog2(STATUS_W) : 1
) (
  input  logic              fail_vld,
  input  logic              fail_wr,
  input  logic [ADDR_W-1:0] fail_addr,
  input  logic              two_ranges,
  input  tcf_mode_e         mode,
  output logic              sync_req,
  output logic              async_req,
  output logic [IDX_W-1:0]  async_idx
);
  always_comb begin
    sync_req  = 1'b0;
    async_req = 1'b0;
    if (fail_vld) begin
      unique case (mode)
        TCF_IGNORE: ;
        TCF_SYNC:   sync_req  = 1'b1;
        TCF_ASYNC:  async_req = 1'b1;
        TCF_ASYM: begin
          async_req = fail_wr;
          sync_req  = !fail_wr;
        end
        default: ;
      endcase
    end
    async_idx = two_ranges ? IDX_W'(fail_addr[SEL_BIT]) : '0;
  end
endmodule

// File: rtl/tcf_status_bank.sv
module tcf_status_bank #(
  parameter int NUM_LVL  = 4,
  parameter int STATUS_W = 2,
  localparam int LVL_W   = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1,
  localparam int IDX_W   = (STATUS_W > 1) ? $clog2(STATUS_W) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                set_vld,
  input  logic [LVL_W-1:0]    set_lvl,
  input  logic [IDX_W-1:0]    set_idx,
  input  logic                wr_en,
  input  logic [LVL_W-1:0]    wr_lvl,
  input  logic [STATUS_W-1:0] wr_data,
  input  logic [LVL_W-1:0]    rd_lvl,
  output logic [STATUS_W-1:0] rd_data
);
  logic [STATUS_W-1:0] stat_q [NUM_LVL];

  for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl
    logic [STATUS_W-1:0] stat_d;
    always_comb begin
      stat_d = (wr_en && wr_lvl == LVL_W'(i)) ? wr_data : stat_q[i];
      if (set_vld && set_lvl == LVL_W'(i)) stat_d[set_idx] = 1'b1;
    end
    always_ff @(posedge clk) begin
      if (rst) stat_q[i] <= '0;
      else     stat_q[i] <= stat_d;
    end

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (rst)
      (set_vld && set_lvl == LVL_W'(i)) |=> stat_q[i][$past(set_idx)]); // R8
    AST_NO_SILENT_CLEAR: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && wr_lvl == LVL_W'(i)) |=> ((stat_q[i] & $past(stat_q[i])) == $past(stat_q[i]))); // R8
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= stat_q[rd_lvl];
  end
endmodule

// File: rtl/tcf_dispatch.sv
module tcf_dispatch
  import tcf_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int SEL_BIT  = 55,
  parameter int NUM_LVL  = 4,
  parameter int STATUS_W = 2,
  localparam int MODE_W  = 2,
  localparam int LVL_W   = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1,
  localparam int IDX_W   = (STATUS_W > 1) ? $clog2(STATUS_W) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fail_vld,
  input  logic [ADDR_W-1:0]   fail_addr,
  input  logic                fail_wr,
  input  logic                regime_user,
  input  logic                regime_two_ranges,
  input  logic [2*MODE_W-1:0] ctrl_tcf,
  input  logic [LVL_W-1:0]    fault_lvl,
  input  logic                reg_wr_en,
  input  logic [LVL_W-1:0]    reg_lvl,
  input  logic [STATUS_W-1:0] reg_wdata,
  output logic [STATUS_W-1:0] reg_rdata,
  output logic                abort_vld,
  output logic [ADDR_W-1:0]   abort_addr,
  output logic                abort_wr
);
  tcf_mode_e          mode;
  logic               sync_req;
  logic               async_req;
  logic [IDX_W-1:0]   async_idx;

  tcf_mode_sel #(.MODE_W(MODE_W)) u_mode (
    .ctrl_tcf    (ctrl_tcf),
    .regime_user (regime_user),
    .mode        (mode)
  );

  tcf_route #(.ADDR_W(ADDR_W), .SEL_BIT(SEL_BIT), .STATUS_W(STATUS_W)) u_route (
    .fail_vld   (fail_vld),
    .fail_wr    (fail_wr),
    .fail_addr  (fail_addr),
    .two_ranges (regime_two_ranges),
    .mode       (mode),
    .sync_req   (sync_req),
    .async_req  (async_req),
    .async_idx  (async_idx)
  );

  tcf_status_bank #(.NUM_LVL(NUM_LVL), .STATUS_W(STATUS_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .set_vld (async_req),
    .set_lvl (fault_lvl),
    .set_idx (async_idx),
    .wr_en   (reg_wr_en),
    .wr_lvl  (reg_lvl),
    .wr_data (reg_wdata),
    .rd_lvl  (reg_lvl),
    .rd_data (reg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      abort_vld  <= 1'b0;
      abort_addr <= '0;
      abort_wr   <= 1'b0;
    end else begin
      abort_vld <= sync_req;
      if (sync_req) begin
        abort_addr <= fail_addr;
        abort_wr   <= fail_wr;
      end
    end
  end

  AST_ABORT_NEEDS_FAIL: assert property (@(posedge clk) disable iff (rst)
    abort_vld |-> $past(fail_vld)); // R9
  AST_ABORT_CARRIES: assert property (@(posedge clk) disable iff (rst)
    abort_vld |-> (abort_addr == $past(fail_addr) && abort_wr == $past(fail_wr))); // R4
  AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (fail_vld && mode == TCF_IGNORE) |=> !abort_vld); // R3
  AST_ASYNC_NO_ABORT: assert property (@(posedge clk) disable iff (rst)
    (fail_vld && (mode == TCF_ASYNC || (mode == TCF_ASYM && fail_wr))) |=> !abort_vld); // R6
endmodule

// File: tb/tb_tcf_dispatch.sv
module tb_tcf_dispatch;
  logic        clk = 1'b0;
  logic        rst;
  logic        fail_vld, fail_wr, regime_user, regime_two_ranges, reg_wr_en;
  logic [63:0] fail_addr;
  logic [3:0]  ctrl_tcf;
  logic [1:0]  fault_lvl, reg_lvl, reg_wdata, reg_rdata;
  logic        abort_vld, abort_wr;
  logic [63:0] abort_addr;
  int checks = 0;
  int failures = 0;

  localparam logic [63:0] A_HI = 64'h0080_0000_DEAD_BEE0; // bit 55 set
  localparam logic [63:0] A_LO = 64'h0000_1234_5678_9AB0; // bit 55 clear

  always #10 clk = ~clk;

  tcf_dispatch dut (
    .clk(clk), .rst(rst), .fail_vld(fail_vld), .fail_addr(fail_addr), .fail_wr(fail_wr),
    .regime_user(regime_user), .regime_two_ranges(regime_two_ranges), .ctrl_tcf(ctrl_tcf),
    .fault_lvl(fault_lvl), .reg_wr_en(reg_wr_en), .reg_lvl(reg_lvl), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .abort_vld(abort_vld), .abort_addr(abort_addr), .abort_wr(abort_wr)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_lvl(input logic [1:0] lvl, input logic [1:0] exp, input string req);
    reg_lvl = lvl;
    @(negedge clk);
    chk(reg_rdata === exp, req, 64'(reg_rdata), 64'(exp));
  endtask

  // drive one failure, check the abort outputs and the pulse width
  task automatic fault(input logic [63:0] a, input logic wr, input logic usr, input logic two,
                       input logic [3:0] tcf, input logic [1:0] lvl, input bit exp_abort,
                       input logic [1:0] wlvl, input bit do_wr, input logic [1:0] wdata,
                       input string req);
    fail_vld = 1'b1; fail_addr = a; fail_wr = wr; regime_user = usr;
    regime_two_ranges = two; ctrl_tcf = tcf; fault_lvl = lvl;
    reg_wr_en = do_wr; reg_lvl = wlvl; reg_wdata = wdata;
    @(negedge clk);
    fail_vld = 1'b0; reg_wr_en = 1'b0;
    chk(abort_vld === exp_abort, req, 64'(abort_vld), 64'(exp_abort));
    if (exp_abort) begin
      chk(abort_addr === a, req, abort_addr, a);
      chk(abort_wr === wr, req, 64'(abort_wr), 64'(wr));
    end
    @(negedge clk);
    chk(abort_vld === 1'b0, "R9 pulse", 64'(abort_vld), 64'h0);
  endtask

  task automatic t_reset();
    chk(abort_vld === 1'b0, "R1 abort", 64'(abort_vld), 64'h0);
    for (int i = 0; i < 4; i++) read_lvl(2'(i), 2'b00, "R1 status");
  endtask

  task automatic t_ignore();
    // user regime: user pair 0, other pair 2 -> must ignore
    fault(A_HI, 1'b1, 1'b1, 1'b1, 4'b1000, 2'd0, 1'b0, 2'd0, 1'b0, 2'b00, "R3 R2 ignore");
    read_lvl(2'd0, 2'b00, "R3 status untouched");
  endtask

  task automatic t_sync();
    fault(A_LO, 1'b0, 1'b0, 1'b1, 4'b0100, 2'd0, 1'b1, 2'd0, 1'b0, 2'b00, "R4 sync load");
    fault(A_HI, 1'b1, 1'b1, 1'b1, 4'b0001, 2'd0, 1'b1, 2'd0, 1'b0, 2'b00, "R4 R2 sync store user");
    read_lvl(2'd0, 2'b00, "R4 no status");
  endtask

  task automatic t_async();
    fault(A_HI, 1'b0, 1'b0, 1'b1, 4'b1000, 2'd1, 1'b0, 2'd0, 1'b0, 2'b00, "R5 async");
    read_lvl(2'd1, 2'b10, "R5 R7 two ranges bit55");
    fault(A_HI, 1'b0, 1'b1, 1'b0, 4'b0110, 2'd2, 1'b0, 2'd0, 1'b0, 2'b00, "R5 R2 async user");
    read_lvl(2'd2, 2'b01, "R7 one range idx0");
    read_lvl(2'd3, 2'b00, "R10 other level");
    read_lvl(2'd0, 2'b00, "R10 level0");
  endtask

  task automatic t_sticky();
    fault(A_LO, 1'b0, 1'b0, 1'b1, 4'b1000, 2'd1, 1'b0, 2'd0, 1'b0, 2'b00, "R8 accumulate");
    read_lvl(2'd1, 2'b11, "R8 sticky OR");
    reg_lvl = 2'd1; reg_wdata = 2'b00; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
    read_lvl(2'd1, 2'b00, "R8 write clears");
    read_lvl(2'd2, 2'b01, "R10 write other level");
    fault(A_HI, 1'b1, 1'b0, 1'b1, 4'b1000, 2'd1, 1'b0, 2'd1, 1'b1, 2'b00, "R8 write+fail");
    read_lvl(2'd1, 2'b10, "R8 same-cycle merge");
  endtask

  task automatic t_asym();
    fault(A_HI, 1'b1, 1'b0, 1'b0, 4'b1100, 2'd3, 1'b0, 2'd0, 1'b0, 2'b00, "R6 asym store");
    read_lvl(2'd3, 2'b01, "R6 store async");
    fault(A_LO, 1'b0, 1'b0, 1'b0, 4'b1100, 2'd3, 1'b1, 2'd0, 1'b0, 2'b00, "R6 asym load");
    read_lvl(2'd3, 2'b01, "R6 load no status");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; fail_vld = 1'b0; fail_wr = 1'b0; fail_addr = '0; regime_user = 1'b0;
    regime_two_ranges = 1'b0; ctrl_tcf = '0; fault_lvl = '0; reg_wr_en = 1'b0;
    reg_lvl = '0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ignore();
    t_sync();
    t_async();
    t_sticky();
    t_asym();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule